// File: doc/BRIEF.md
# Asynchronous SRAM Bridge

This block lets a clocked host read and write a byte-wide asynchronous static RAM with an 18-bit word address. It drives two chip selects of opposite polarity, an active-low select and an active-high select. It also drives an active-low write strobe and an active-low output enable, and it decides when the controller itself drives the shared data bus. The RAM has no clock, so every access is stretched over a whole number of controller clock cycles. Each phase length is the ceiling of a nanosecond minimum divided by the clock period, and never less than one cycle.

The host side is a level request with an acknowledge. The host raises `req` with `we`, `addr` and `wdata` and holds them until it sees a one-cycle `ack`. For a read, `rdata` is valid together with that `ack`. Between accesses the RAM is left deselected: both selects are inactive, both strobes are high and the controller does not drive the bus. A write that follows a read waits until the RAM's outputs have had time to float before the controller drives data.

Top module: `asram_bridge`

## Requirements
- R1: After reset, and in every cycle with no access in progress (including the acknowledge cycle), `mem_sel_n`=1, `mem_sel`=0, `mem_wr_n`=1, `mem_rd_n`=1, `mem_drive`=0, and `ack` is 0 outside its pulse.
- R2: A read asserts both selects and `mem_rd_n`=0, with `mem_wr_n`=1, for RD_CYC cycles. RD_CYC is 11 with the default parameters. `rdata` takes `mem_din` at the edge that closes this window and is valid together with `ack`.
- R3: A write first gives AS_CYC setup cycles (1 by default) with both selects active and `mem_wr_n` high. `mem_wr_n` then stays low for exactly WP_CYC cycles (9 by default). `mem_wr_n` is low only while both selects are active, and `mem_rd_n` stays high throughout.
- R4: `addr` is captured when a request is accepted. `mem_addr` does not change while a select is active.
- R5: Write data is driven on `mem_dout` with `mem_drive`=1 from the setup cycle through WR_CYC recovery cycles after `mem_wr_n` rises, with the selects already released. `mem_drive` is never 1 while `mem_rd_n` is 0.
- R6: After a read, `mem_drive` does not rise until REL_CYC cycles after `mem_rd_n` has risen (4 by default). A read request is not delayed by this wait.
- R7: `ack` is a one-cycle pulse. A request is not accepted in the cycle in which `ack` is high. From the accepting edge to the edge that raises `ack` there are RD_CYC cycles for a read and AS_CYC+WP_CYC+WR_CYC cycles for a write (11 and 11 by default).
- R8: Each phase length is ceil(ns/CLK_PERIOD_NS), with a minimum of 1:
  - RD_CYC is the largest of the read cycle, address access and enable access values.
  - WP_CYC is the largest of the strobe width, the address-to-strobe-end time less AS_CYC, and the data setup time less AS_CYC.
  - WR_CYC is the write cycle less AS_CYC+WP_CYC, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Word address |
| wdata | input | 8 | Write byte |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read byte, valid with ack |
| mem_addr | output | 18 | Address to the RAM |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low output enable |
| mem_dout | output | 8 | Data driven toward the RAM |
| mem_drive | output | 1 | 1 = controller drives the data bus |
| mem_din | input | 8 | Data returned from the RAM |

## Verification
The case that is hardest to reach from the ports is a write that arrives immediately after a read. Here the turnaround wait, not the acknowledge cycle, sets when the access is accepted. The case is harder still when a few idle cycles partly cover that wait. The stimulus strings reads and writes back to back, with random gaps of zero to five cycles. A behavioural RAM model ticking every nanosecond keeps driving the bus for the release time after the enable rises. It also returns garbage until the access time has passed, so any early drive or early capture shows up as a contention report or a wrong read byte.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WSETUP = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WRECOV = 3'd4
  } asram_state_e;

  // Whole clock cycles that cover a nanosecond minimum, never fewer than one.
  function automatic int span_cycles(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_down_cnt.sv
module asram_down_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load | ~zero;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int RD_CYC = 11,
  parameter int AS_CYC = 1,
  parameter int WP_CYC = 9,
  parameter int WR_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             we,
  input  logic             ph_zero,
  input  logic             turn_zero,
  output logic             ph_load,
  output logic [CNT_W-1:0] ph_val,
  output logic             turn_load,
  output logic             cap_req,
  output logic             cap_rd,
  output logic             ack,
  output logic             sel_n,
  output logic             sel,
  output logic             wr_n,
  output logic             rd_n,
  output logic             drive
);

  asram_state_e st_q, st_d;
  logic ack_d, sel_d, wr_d, rd_d, drv_d;

  // next-state and phase-counter control
  always_comb begin
    st_d      = st_q;
    ph_load   = 1'b0;
    ph_val    = '0;
    turn_load = 1'b0;
    cap_req   = 1'b0;
    cap_rd    = 1'b0;
    ack_d     = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req && !ack && (!we || turn_zero)) begin
          cap_req = 1'b1;
          ph_load = 1'b1;
          if (we) begin
            st_d   = ST_WSETUP;
            ph_val = CNT_W'(AS_CYC - 1);
          end else begin
            st_d   = ST_READ;
            ph_val = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_READ: begin
        if (ph_zero) begin
          st_d      = ST_IDLE;
          cap_rd    = 1'b1;
          turn_load = 1'b1;
          ack_d     = 1'b1;
        end
      end
      ST_WSETUP: begin
        if (ph_zero) begin
          st_d    = ST_WPULSE;
          ph_load = 1'b1;
          ph_val  = CNT_W'(WP_CYC - 1);
        end
      end
      ST_WPULSE: begin
        if (ph_zero) begin
          st_d    = ST_WRECOV;
          ph_load = 1'b1;
          ph_val  = CNT_W'(WR_CYC - 1);
        end
      end
      ST_WRECOV: begin
        if (ph_zero) begin
          st_d  = ST_IDLE;
          ack_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // strobe levels decoded from the next state so that every pin leaves a flop
  always_comb begin
    sel_d = (st_d == ST_READ) || (st_d == ST_WSETUP) || (st_d == ST_WPULSE);
    wr_d  = (st_d == ST_WPULSE);
    rd_d  = (st_d == ST_READ);
    drv_d = (st_d == ST_WSETUP) || (st_d == ST_WPULSE) || (st_d == ST_WRECOV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ack   <= 1'b0;
      sel_n <= 1'b1;
      sel   <= 1'b0;
      wr_n  <= 1'b1;
      rd_n  <= 1'b1;
      drive <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack   <= ack_d;
      sel_n <= ~sel_d;
      sel   <= sel_d;
      wr_n  <= ~wr_d;
      rd_n  <= ~rd_d;
      drive <= drv_d;
    end
  end

  // R3: the strobe only falls once both selects were already active
  p_wfall_after_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> ($past(!sel_n) && $past(sel)));

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_req,
  input  logic              cap_rd,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_din,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_dout <= '0;
    end else if (cap_req) begin
      mem_addr <= addr_i;
      mem_dout <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (cap_rd) rdata <= mem_din;
  end

endmodule

// File: rtl/asram_bridge.sv
module asram_bridge
  import asram_pkg::*;
#(
  parameter int ADDR_W         = 18,
  parameter int DATA_W         = 8,
  parameter int CLK_PERIOD_NS  = 5,
  parameter int T_RD_CYCLE_NS  = 55,
  parameter int T_ADDR_ACC_NS  = 55,
  parameter int T_EN_ACC_NS    = 30,
  parameter int T_WR_CYCLE_NS  = 55,
  parameter int T_STROBE_NS    = 45,
  parameter int T_ADDR_WEND_NS = 50,
  parameter int T_DSETUP_NS    = 25,
  parameter int T_ASETUP_NS    = 0,
  parameter int T_RELEASE_NS   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_wr_n,
  output logic              mem_rd_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_drive,
  input  logic [DATA_W-1:0] mem_din
);

  // R8: phase lengths in clock cycles
  localparam int RD_CYC = imax(span_cycles(T_RD_CYCLE_NS, CLK_PERIOD_NS),
                               imax(span_cycles(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                                    span_cycles(T_EN_ACC_NS, CLK_PERIOD_NS)));
  localparam int AS_CYC = span_cycles(T_ASETUP_NS, CLK_PERIOD_NS);
  localparam int WP_CYC = imax(span_cycles(T_STROBE_NS, CLK_PERIOD_NS),
                               imax(span_cycles(T_ADDR_WEND_NS, CLK_PERIOD_NS) - AS_CYC,
                                    span_cycles(T_DSETUP_NS, CLK_PERIOD_NS) - AS_CYC));
  localparam int WR_CYC = imax(1, span_cycles(T_WR_CYCLE_NS, CLK_PERIOD_NS) - AS_CYC - WP_CYC);
  localparam int REL_CYC = span_cycles(T_RELEASE_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC = imax(imax(RD_CYC, AS_CYC), imax(imax(WP_CYC, WR_CYC), REL_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int CHK_W   = CNT_W + 1;

  logic             ph_load, ph_zero, turn_load, turn_zero, cap_req, cap_rd;
  logic [CNT_W-1:0] ph_val;

  asram_seq #(
    .CNT_W (CNT_W),
    .RD_CYC(RD_CYC),
    .AS_CYC(AS_CYC),
    .WP_CYC(WP_CYC),
    .WR_CYC(WR_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .we       (we),
    .ph_zero  (ph_zero),
    .turn_zero(turn_zero),
    .ph_load  (ph_load),
    .ph_val   (ph_val),
    .turn_load(turn_load),
    .cap_req  (cap_req),
    .cap_rd   (cap_rd),
    .ack      (ack),
    .sel_n    (mem_sel_n),
    .sel      (mem_sel),
    .wr_n     (mem_wr_n),
    .rd_n     (mem_rd_n),
    .drive    (mem_drive)
  );

  // phase timer
  asram_down_cnt #(.CNT_W(CNT_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ph_load),
    .load_val(ph_val),
    .zero    (ph_zero)
  );

  // bus-release timer started when a read window closes
  asram_down_cnt #(.CNT_W(CNT_W)) u_turn (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (turn_load),
    .load_val(CNT_W'(REL_CYC - 1)),
    .zero    (turn_zero)
  );

  asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_req (cap_req),
    .cap_rd  (cap_rd),
    .addr_i  (addr),
    .wdata_i (wdata),
    .mem_din (mem_din),
    .mem_addr(mem_addr),
    .mem_dout(mem_dout),
    .rdata   (rdata)
  );

  // checker counters: strobe-low run length and enable-high run length
  logic [CHK_W-1:0] wlow_cnt, rdhi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wlow_cnt <= '0;
    else if (!mem_wr_n) wlow_cnt <= wlow_cnt + 1'b1;
    else                wlow_cnt <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              rdhi_cnt <= CHK_W'(REL_CYC);
    else if (!mem_rd_n)                      rdhi_cnt <= '0;
    else if (rdhi_cnt < CHK_W'(REL_CYC))     rdhi_cnt <= rdhi_cnt + 1'b1;
  end

  p_desel_on_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !mem_drive));

  p_wr_inside_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> (!mem_sel_n && mem_sel && mem_rd_n && mem_drive));

  p_wr_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_n && !$past(mem_wr_n)) |-> (wlow_cnt == CHK_W'(WP_CYC)));

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && !$past(mem_sel_n)) |-> $stable(mem_addr));

  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_drive |-> mem_rd_n);

  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_drive && !$past(mem_drive)) |-> (rdhi_cnt >= CHK_W'(REL_CYC)));

  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

endmodule

// File: tb/asram_bridge_test.sv
`timescale 1ns/1ps
module asram_bridge_test;

  localparam real PERIOD = 5.0;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + 4) / 5;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // expected phase lengths from R8 (5 ns clock)
  localparam int E_RD  = mx(cyc(55), mx(cyc(55), cyc(30)));
  localparam int E_AS  = cyc(0);
  localparam int E_WP  = mx(cyc(45), mx(cyc(50) - E_AS, cyc(25) - E_AS));
  localparam int E_WR  = mx(1, cyc(55) - E_AS - E_WP);
  localparam int E_REL = cyc(20);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, we;
  logic [17:0] addr;
  logic [7:0]  wdata;
  logic        ack;
  logic [7:0]  rdata;
  logic [17:0] mem_addr;
  logic        mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_drive;
  logic [7:0]  mem_dout;
  logic [7:0]  mem_din;

  always #(PERIOD/2) clk = ~clk;

  asram_bridge uut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ack(ack), .rdata(rdata), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
    .mem_sel(mem_sel), .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n),
    .mem_dout(mem_dout), .mem_drive(mem_drive), .mem_din(mem_din)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural RAM on a 1 ns tick ----------------
  logic [7:0] sram_arr [int];
  logic [7:0] ref_mem  [int];
  real        rd_t0, rd_end_t, wr_t0;
  logic       prev_rd, prev_wr;
  logic [17:0] rd_a, wr_a;

  function automatic logic [7:0] sram_get(input logic [17:0] a);
    return sram_arr.exists(int'(a)) ? sram_arr[int'(a)] : 8'h00;
  endfunction
  function automatic logic [7:0] ref_get(input logic [17:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
  endfunction

  initial begin
    mem_din  = 8'h5A;
    prev_rd  = 1'b0;
    prev_wr  = 1'b0;
    rd_end_t = -100.0;
    rd_t0    = 0.0;
    wr_t0    = 0.0;
    rd_a     = '0;
    wr_a     = '0;
    forever begin
      logic rd_act, wr_act, model_drv;
      #1;
      rd_act = !mem_sel_n && mem_sel && mem_wr_n && !mem_rd_n;
      wr_act = !mem_sel_n && mem_sel && !mem_wr_n;
      if (rd_act && (!prev_rd || mem_addr != rd_a)) begin
        rd_t0 = $realtime;
        rd_a  = mem_addr;
      end
      if (!rd_act && prev_rd) rd_end_t = $realtime;
      // data valid after the access time (1 ns tick tolerance)
      if (rd_act) mem_din = (($realtime - rd_t0) >= 54.0) ? sram_get(rd_a) : 8'hA5;
      model_drv = rd_act || (($realtime - rd_end_t) < 20.0);
      if (model_drv && mem_drive) check(1'b0, "R6 bus contention", 1, 0);
      if (wr_act && !prev_wr) begin
        wr_t0 = $realtime;
        wr_a  = mem_addr;
        if (!mem_drive) check(1'b0, "R5 data not driven at strobe fall", 0, 1);
      end
      if (wr_act && prev_wr && mem_addr != wr_a)
        check(1'b0, "R4 address moved during write", int'(mem_addr), int'(wr_a));
      if (!wr_act && prev_wr) begin
        if (($realtime - wr_t0) < 45.0)
          check(1'b0, "R3 strobe too short", int'($realtime - wr_t0), 45);
        if (!mem_drive) check(1'b0, "R5 data hold lost", 0, 1);
        sram_arr[int'(wr_a)] = mem_dout;
      end
      prev_rd = rd_act;
      prev_wr = wr_act;
    end
  end

  // ---------------- host driver and cycle-level reference ----------------
  int  since_ack = 100;
  bit  had_ack   = 1'b0;
  bit  last_read = 1'b0;

  task automatic idle_check(input string tag);
    check(mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !mem_drive,
          tag, {mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_drive}, 5'b10110);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      idle_check("R1 idle deselect");
      check(!ack, "R7 no stray ack", ack, 0);
    end
    since_ack += n;
  endtask

  task automatic do_op(input bit w, input logic [17:0] a, input logic [7:0] d);
    int need, j, total;
    logic [7:0] exp_rd;
    need = had_ack ? 2 : 1;
    if (w && last_read) need = mx(need, E_REL);
    j = mx(1, need - since_ack);
    total = j + (w ? (E_AS + E_WP + E_WR) : E_RD);
    exp_rd = ref_get(a);
    req = 1'b1; we = w; addr = a; wdata = d;
    for (int k = 1; k <= total; k++) begin
      @(posedge clk); @(negedge clk);
      check(ack == (k == total), "R7 ack timing", ack, (k == total));
      if (k < j) idle_check(w ? "R6 write waits deselected" : "R7 request waits");
      if (k == j) begin
        check(mem_addr == a, "R4 address presented", int'(mem_addr), int'(a));
        if (w) check(!mem_sel_n && mem_sel && mem_wr_n && mem_rd_n && mem_drive,
                     "R3 setup cycle", {mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_drive}, 5'b01111);
        else   check(!mem_sel_n && mem_sel && mem_wr_n && !mem_rd_n && !mem_drive,
                     "R2 read strobes", {mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_drive}, 5'b01100);
      end
      if (w && k == j + E_AS)
        check(!mem_wr_n && mem_rd_n, "R3 strobe low", {mem_wr_n, mem_rd_n}, 2'b01);
      if (w && k == j + E_AS + E_WP - 1)
        check(!mem_wr_n, "R8 strobe still low at last pulse cycle", mem_wr_n, 0);
      if (w && k == j + E_AS + E_WP)
        check(mem_wr_n && mem_sel_n && mem_drive && mem_dout == d,
              "R5 recovery hold", {mem_wr_n, mem_sel_n, mem_drive}, 3'b111);
      if (!w && k == j + E_RD - 1)
        check(!mem_rd_n && !mem_sel_n, "R2 window still open", mem_rd_n, 0);
      if (k == total) begin
        idle_check("R1 deselect in ack cycle");
        if (!w) check(rdata == exp_rd, "R2 read data", int'(rdata), int'(exp_rd));
      end
    end
    req = 1'b0;
    if (w) ref_mem[int'(a)] = d;
    since_ack = 0;
    had_ack   = 1'b1;
    last_read = !w;
  endtask

  // watchdog
  initial begin
    #(200000 * PERIOD);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R7 watchdog actual=hung expected=complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  logic [17:0] pool [16];

  initial begin
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    for (int i = 0; i < 16; i++) pool[i] = 18'((i * 18'h2B4D1 + 18'h155) & 18'h3FFFF);
    pool[0]  = 18'h00000;
    pool[15] = 18'h3FFFF;
    repeat (3) @(negedge clk);
    idle_check("R1 reset state");
    check(!ack && rdata == 8'h00, "R1 reset ack/rdata", {ack, rdata}, 0);
    rst_n = 1'b1;
    idle(3);

    // directed: boundaries, back-to-back, turnaround with partial gaps
    do_op(1'b1, 18'h00000, 8'h3C);
    do_op(1'b1, 18'h3FFFF, 8'hC3);
    do_op(1'b0, 18'h00000, 8'h00);
    do_op(1'b0, 18'h3FFFF, 8'h00);
    do_op(1'b1, 18'h00000, 8'h96);   // write right after read: R6 wait
    do_op(1'b0, 18'h00000, 8'h00);
    idle(1);
    do_op(1'b1, 18'h3FFFF, 8'h69);   // R6 wait partly covered by a gap
    do_op(1'b0, 18'h3FFFF, 8'h00);
    idle(6);
    do_op(1'b1, 18'h12345, 8'hFF);   // R6 wait fully covered
    do_op(1'b0, 18'h12345, 8'h00);

    // random back-to-back mix
    for (int n = 0; n < 300; n++) begin
      bit w;
      w = $urandom_range(0, 1) == 1;
      do_op(w, pool[$urandom_range(0, 15)], 8'($urandom));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 5));
    end

    idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule